// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block is a bus master that moves one operand of one to four bytes between a requester and a memory port. The port reports its width (32, 16 or 8 bits) only when it ends each bus cycle. From that report the sequencer works out how many bytes the cycle carried and which data lanes held them. It then advances the address, counts down the bytes left and starts further cycles until the whole operand has moved. Any byte alignment is allowed. A requester pulses `req_valid` while the block is idle, then waits for the one-clock `done` pulse. For reads, it collects the result on `rdata`.

The state machine has five states. `ST_IDLE` waits for a request, and a request moves it to `ST_ADDR`. `ST_ADDR` drives the address and the bytes-left size with the strobe high, then moves to `ST_DATA`. `ST_DATA` keeps the strobe high and samples the acknowledge. The wait code keeps it in `ST_DATA`; any width code latches the lanes and moves it to `ST_TERM`. In `ST_TERM` the strobe is low. If bytes are still left it goes back to `ST_ADDR`, otherwise to `ST_DONE`. `ST_DONE` raises `done` for one clock and returns to `ST_IDLE`. Each bus cycle therefore takes at least three clocks.

The lanes are named by byte position on the data bus, lane 0 being bits 31:24 and lane 3 being bits 7:0. A 32-bit port uses all four lanes. A 16-bit port uses lanes 0 and 1, and an 8-bit port uses lane 0 only.

Top module: `dyn_bus_sizer`

## Requirements
- R1: After reset, `busy`, `done` and `bus_strobe` are all low.
- R2: Each bus cycle presents `bus_addr` equal to the address of the next operand byte still to move. It presents `bus_siz` equal to the bytes still to move, coded 1, 2 and 3 as themselves and four as 0.
- R3: `bus_ack` is coded 00 for a 32-bit port, 01 for a 16-bit port, 10 for an 8-bit port and 11 for wait. While the code is 11 the strobe stays high and the address and size hold. Strobe-high time is max(2, 1+w) clocks, where w is the number of clocks the port withholds its code after the first strobed clock.
- R4: The strobe is high for at least two clocks per bus cycle and low for at least one clock between cycles. It is never high while `busy` is low.
- R5: A cycle moves min(W - (addr mod W), bytes left) bytes, where W is the port width in bytes. The address advances by that count, and cycles repeat until no byte is left. The number of cycles equals the number computed this way.
- R6: On reads, the byte for address a comes from lane (a mod 4) on a 32-bit port, lane (a mod 2) on a 16-bit port and lane 0 on an 8-bit port.
- R7: `rdata` holds the read operand right-justified, with the lowest-addressed byte most significant and unused upper bytes zero. `done` is high for exactly one clock, and `rdata` keeps its value after `done`.
- R8: On writes, each byte reaches the port on the lane R6 names for its address. The lanes that narrower ports use repeat the bytes due at the current address, so the memory ends up holding the operand bytes in address order and nothing outside them changes.
- R9: `req_valid` is ignored while `busy` is high. It adds no bus cycle and changes no result.
- R10: `req_size` codes 01, 10 and 11 select 1, 2 and 3 bytes, and 00 selects four bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, sampled while idle |
| req_write | input | 1 | 1 = write operand, 0 = read |
| req_size | input | 2 | Operand byte count (00 = four) |
| req_addr | input | ADDR_W | Address of the operand's first byte |
| req_wdata | input | 32 | Write operand, right-justified |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read operand, right-justified |
| bus_strobe | output | 1 | Bus cycle active |
| bus_write | output | 1 | Current cycle is a write |
| bus_addr | output | ADDR_W | Address of the current cycle |
| bus_siz | output | 2 | Bytes still to move (00 = four) |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_ack | input | 2 | Port width or wait code |

## Verification
The assertions assume that `bus_ack` is only ever one of its four codes. They also assume that the port gives a width code only while the strobe is high, and returns to the wait code once the strobe drops. The port model in the bench keeps to this. It drives the acknowledge on the falling edge, and only after it has counted its configured wait clocks on the strobe. It presents the wait code whenever the strobe is low. The bench also assumes that `req_valid` is held for a single clock. Its only pulse during a busy period is a deliberate one, used to exercise R9.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int CNT_W  = $clog2(LANES) + 1;
    localparam int IDX_W  = $clog2(LANES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_TERM,
        ST_DONE
    } dbs_state_t;

    localparam logic [1:0] ACK_W32  = 2'b00;
    localparam logic [1:0] ACK_W16  = 2'b01;
    localparam logic [1:0] ACK_W8   = 2'b10;
    localparam logic [1:0] ACK_WAIT = 2'b11;

    typedef logic [LANES-1:0][BYTE_W-1:0] lane_bytes_t;

    function automatic logic [CNT_W-1:0] port_bytes(input logic [1:0] code);
        unique case (code)
            ACK_W32: port_bytes = CNT_W'(4);
            ACK_W16: port_bytes = CNT_W'(2);
            default: port_bytes = CNT_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/dbs_lane_steer.sv
module dbs_lane_steer
    import dbs_pkg::*;
(
    input  logic [1:0]       addr_lo,
    input  logic [CNT_W-1:0] rem,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       ack,
    input  logic [DATA_W-1:0] din,
    input  lane_bytes_t      wbytes,
    output logic [CNT_W-1:0] acc,
    output lane_bytes_t      rd_bytes,
    output logic [DATA_W-1:0] dout
);
    logic [1:0]       off;
    logic [CNT_W-1:0] room;
    logic [BYTE_W-1:0] lane_in [LANES];

    always_comb begin
        unique case (ack)
            ACK_W32: off = addr_lo;
            ACK_W16: off = {1'b0, addr_lo[0]};
            default: off = 2'b00;
        endcase
        room = port_bytes(ack) - CNT_W'(off);
        acc  = (room < rem) ? room : rem;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_in[j] = din[DATA_W-1-BYTE_W*j -: BYTE_W];

        logic [1:0] rd_sel;
        assign rd_sel      = off + 2'(j);
        assign rd_bytes[j] = lane_in[rd_sel];

        logic [1:0] w_off;
        logic [1:0] w_sel;
        always_comb begin
            if (2'(j) >= addr_lo)
                w_off = 2'(j) - addr_lo;
            else if (j < 2 && 2'(j) >= {1'b0, addr_lo[0]})
                w_off = 2'(j) - {1'b0, addr_lo[0]};
            else
                w_off = 2'b00;
            w_sel = idx + w_off;
        end
        assign dout[DATA_W-1-BYTE_W*j -: BYTE_W] = wbytes[w_sel];
    end
endmodule

// File: rtl/dbs_assemble.sv
module dbs_assemble
    import dbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CNT_W-1:0]  acc,
    input  lane_bytes_t       rd_bytes,
    input  logic [CNT_W-1:0]  nbytes,
    output logic [DATA_W-1:0] rdata
);
    lane_bytes_t buf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (clear) begin
            buf_q <= '0;
        end else if (capture) begin
            for (int i = 0; i < LANES; i++) begin
                if (CNT_W'(i) < acc)
                    buf_q[idx + IDX_W'(i)] <= rd_bytes[i];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < LANES; p++) begin
            if (CNT_W'(p) < nbytes)
                rdata[BYTE_W*p +: BYTE_W] = buf_q[IDX_W'(nbytes - CNT_W'(1) - CNT_W'(p))];
        end
    end
endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rdata,
    output logic              bus_strobe,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_siz,
    output logic [31:0]       bus_dout,
    input  logic [31:0]       bus_din,
    input  logic [1:0]        bus_ack
);
    dbs_state_t state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q, n_q, acc, req_n;
    logic [IDX_W-1:0]  idx_q;
    logic              wr_q;
    lane_bytes_t       wb_q, wb_load, rd_bytes;
    logic              start, accept;

    assign start  = (state_q == ST_IDLE) && req_valid;
    assign accept = (state_q == ST_DATA) && (bus_ack != ACK_WAIT);
    assign req_n  = (req_size == 2'b00) ? CNT_W'(4) : CNT_W'(req_size);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: if (bus_ack != ACK_WAIT) state_d = ST_TERM;
            ST_TERM: state_d = (rem_q == '0) ? ST_DONE : ST_ADDR;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs from state
    always_comb begin
        busy       = 1'b1;
        done       = 1'b0;
        bus_strobe = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_ADDR: bus_strobe = 1'b1;
            ST_DATA: bus_strobe = 1'b1;
            ST_TERM: bus_strobe = 1'b0;
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign bus_write = wr_q & bus_strobe;
    assign bus_addr  = addr_q;
    assign bus_siz   = rem_q[1:0];

    // Left-justify the write operand by address order
    always_comb begin
        int b;
        wb_load = '0;
        for (int k = 0; k < LANES; k++) begin
            b = int'(req_n) - 1 - k;
            if (b >= 0)
                wb_load[k] = req_wdata[BYTE_W*b +: BYTE_W];
        end
    end

    // Transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
            n_q    <= '0;
            idx_q  <= '0;
            wr_q   <= 1'b0;
            wb_q   <= '0;
        end else if (start) begin
            addr_q <= req_addr;
            rem_q  <= req_n;
            n_q    <= req_n;
            idx_q  <= '0;
            wr_q   <= req_write;
            wb_q   <= wb_load;
        end else if (accept) begin
            addr_q <= addr_q + ADDR_W'(acc);
            rem_q  <= rem_q - acc;
            idx_q  <= idx_q + IDX_W'(acc);
        end
    end

    dbs_lane_steer u_steer (
        .addr_lo  (addr_q[1:0]),
        .rem      (rem_q),
        .idx      (idx_q),
        .ack      (bus_ack),
        .din      (bus_din),
        .wbytes   (wb_q),
        .acc      (acc),
        .rd_bytes (rd_bytes),
        .dout     (bus_dout)
    );

    dbs_assemble u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .capture  (accept && !wr_q),
        .idx      (idx_q),
        .acc      (acc),
        .rd_bytes (rd_bytes),
        .nbytes   (n_q),
        .rdata    (rdata)
    );

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && bus_ack == ACK_WAIT) |=> (bus_strobe && $stable(bus_addr) && $stable(bus_siz))); // R3
    AST_STROBE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_strobe) |=> bus_strobe); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_strobe); // R4
    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (acc != '0 && acc <= rem_q)); // R5
    AST_LIVE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |-> (rem_q != '0)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
endmodule

// File: tb/sim_dyn_bus_sizer.sv
module sim_dyn_bus_sizer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        busy, done, bus_strobe, bus_write;
    logic [31:0] rdata, bus_addr, bus_dout;
    logic [1:0]  bus_siz;
    logic [31:0] bus_din = '0;
    logic [1:0]  bus_ack = 2'b11;

    always #(CLK_PERIOD/2) clk = ~clk;

    dyn_bus_sizer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .bus_strobe(bus_strobe),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_siz(bus_siz),
        .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack(bus_ack)
    );

    typedef struct { logic [31:0] addr; logic [1:0] siz; } cyc_t;
    cyc_t exp_q[$];

    int n_checks = 0, n_fail = 0;
    logic [7:0] mem  [64];
    logic [7:0] gold [64];
    logic [1:0] port_code = 2'b00;
    int         waits = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int wbytes(input logic [1:0] code);
        return (code == 2'b00) ? 4 : (code == 2'b01) ? 2 : 1;
    endfunction

    // Port model and scoreboard monitor
    int hcnt = 0;
    bit prev_strobe = 0;
    logic [31:0] rec_addr, rec_dout;
    logic [1:0]  rec_siz;
    logic        rec_wr;
    always @(negedge clk) begin
        if (!rst_n) begin
            hcnt = 0; prev_strobe = 0; bus_ack = 2'b11;
        end else begin
            if (bus_strobe) begin
                hcnt++;
                rec_addr = bus_addr; rec_siz = bus_siz; rec_dout = bus_dout; rec_wr = bus_write;
                if (hcnt >= 1 + waits) begin
                    int w;
                    logic [31:0] base;
                    w = wbytes(port_code);
                    base = bus_addr & ~(32'(w) - 1);
                    bus_din = 32'hEEEE_EEEE;
                    for (int j = 0; j < w; j++)
                        bus_din[31-8*j -: 8] = mem[(base + 32'(j)) & 63];
                    bus_ack = port_code;
                end else begin
                    bus_ack = 2'b11;
                end
            end else begin
                bus_ack = 2'b11;
                if (prev_strobe) begin
                    int w, off, n, cnt, exp_h;
                    cyc_t e;
                    exp_h = (2 > 1 + waits) ? 2 : 1 + waits;
                    check(hcnt == exp_h, "R3", "strobe clocks", 32'(hcnt), 32'(exp_h));
                    if (exp_q.size() == 0) begin
                        check(0, "R9", "unexpected bus cycle", rec_addr, 32'hFFFF_FFFF);
                    end else begin
                        e = exp_q.pop_front();
                        check(rec_addr == e.addr, "R2", "cycle address", rec_addr, e.addr);
                        check(rec_siz == e.siz, "R2", "cycle size", 32'(rec_siz), 32'(e.siz));
                    end
                    if (rec_wr) begin
                        w = wbytes(port_code);
                        off = int'(rec_addr) % w;
                        n = (rec_siz == 0) ? 4 : int'(rec_siz);
                        cnt = (w - off < n) ? w - off : n;
                        for (int i = 0; i < cnt; i++)
                            mem[(rec_addr + 32'(i)) & 63] = rec_dout[31-8*(off+i) -: 8];
                    end
                end
                hcnt = 0;
            end
            prev_strobe = bus_strobe;
        end
    end

    // Driver: pushes expected cycles, then runs one request
    task automatic run_op(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, input bit poke);
        int n, rem, w, acc, t;
        logic [31:0] cur, exp_rd;
        cyc_t e;
        n = (sz == 0) ? 4 : int'(sz);
        w = wbytes(port_code);
        rem = n; cur = a;
        while (rem > 0) begin
            acc = w - int'(cur) % w;
            if (acc > rem) acc = rem;
            e.addr = cur; e.siz = 2'(rem);
            exp_q.push_back(e);
            cur += 32'(acc); rem -= acc;
        end
        exp_rd = '0;
        for (int k = 0; k < n; k++) begin
            if (wr) gold[(a + 32'(k)) & 63] = wd[8*(n-1-k) +: 8];
            exp_rd[8*(n-1-k) +: 8] = mem[(a + 32'(k)) & 63];
        end
        req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        t = 0;
        while (!done && t < 300) begin
            @(negedge clk);
            t++;
            if (poke && t == 3) begin
                req_valid = 1; req_write = ~wr; req_size = 2'b00; req_addr = a + 8; req_wdata = 32'h5A5A5A5A;
            end else begin
                req_valid = 0;
            end
        end
        req_valid = 0;
        check(done == 1, "R7", "done seen", 32'(done), 32'h1);
        check(exp_q.size() == 0, "R5", "cycles left over", 32'(exp_q.size()), 32'h0);
        if (!wr) check(rdata == exp_rd, "R6", "read operand", rdata, exp_rd);
        @(negedge clk);
        check(!done && !busy, "R7", "done one clock", {30'b0, done, busy}, 32'h0);
        if (!wr) check(rdata == exp_rd, "R7", "rdata held", rdata, exp_rd);
        if (wr) begin
            bit ok = 1;
            for (int i = 0; i < 64; i++) if (mem[i] !== gold[i]) ok = 0;
            check(ok, "R8", "memory after write", {24'b0, mem[a & 63]}, {24'b0, gold[a & 63]});
        end
        exp_q.delete();
    endtask

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = 8'(i * 37 + 11);
            gold[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        check(!busy && !done && !bus_strobe, "R1", "reset outputs",
              {29'b0, busy, done, bus_strobe}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        // R10 sizes, R5/R6/R8 all widths and alignments, reads and writes
        for (int pc = 0; pc < 3; pc++) begin
            port_code = 2'(pc);
            for (int s = 0; s < 4; s++)
                for (int al = 0; al < 4; al++) begin
                    run_op(0, 2'(s), 32'(16 + al), 32'h0, 0);
                    run_op(1, 2'(s), 32'(32 + al), 32'hA1B2C3D4 ^ 32'(s * 77 + al * 5), 0);
                end
        end
        // R3 wait states
        waits = 3;
        for (int pc = 0; pc < 3; pc++) begin
            port_code = 2'(pc);
            run_op(0, 2'b00, 32'd13, 32'h0, 0);
            run_op(1, 2'b11, 32'd41, 32'h00C0FFEE, 0);
        end
        waits = 0;
        // R9 request during busy ignored
        port_code = 2'b10;
        run_op(0, 2'b00, 32'd21, 32'h0, 1);
        run_op(1, 2'b10, 32'd49, 32'h0000BEEF, 1);
        repeat (10) @(negedge clk);
        check(!busy && !bus_strobe, "R9", "quiet after ignored request",
              {30'b0, busy, bus_strobe}, 32'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule